// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block is a built-in self-test sequencer for one single-port synchronous RAM. After a one-cycle start pulse it takes a window of cells, a base address plus the offset of the last cell, and runs four march passes over that window. The first pass clears every cell in rising address order. The second pass climbs the window again: it reads each cell, expects all zeros, and writes all ones. The third pass walks down the window: it reads, expects all ones, and writes zeros. The fourth pass also walks down: it reads, expects zeros, and writes ones. The window may wrap past the top of the address space.

Each pass ends with a one-cycle report that carries the pass number and, for the three passes that read, whether any compare failed. The first mismatch in a run is held as a record of the cell address, the pass and the raw word read. A stop-on-fail input, sampled at start, chooses between running on to the end and aborting right after the first failing compare. The RAM has a read latency of one cycle. A read-then-write visit to one cell therefore takes two cycles, and a full run over N cells takes 7·N busy cycles.

Top module: `march_tester`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, fail_o, elem_done_o and ram_en_o are all low.
- R2: Pass 0 writes the all-zeros word once to every cell in rising address order. It spends one cycle per cell, performs no reads, and ram_we_o is never high without ram_en_o.
- R3: Pass 1 visits cells in rising order. At each cell it reads, compares the word returned one cycle later against all zeros, and writes all ones in that same cycle.
- R4: Pass 2 visits cells in falling order. At each cell it reads and expects all ones, then writes all zeros. Where two cells are faulty, the higher address is the first one found.
- R5: Pass 3 visits cells in falling order. At each cell it reads and expects all zeros, then writes all ones, so a clean run leaves every cell of the window at all ones.
- R6: Only cells at base_i + k, for k = 0 … len_i and taken modulo the address space, are accessed. Base and length are captured at start.
- R7: Each read is followed in the next cycle by a write to the same address. A clean run over N = len_i + 1 cells is busy for exactly 7·N cycles, with 3·N reads and 4·N writes.
- R8: At the end of each pass elem_done_o pulses for one cycle. elem_id_o takes the values 0, 1, 2 and 3 in that order, and elem_fail_o is 1 when that pass saw a mismatch. For pass 0 it is always 0.
- R9: The first mismatch of a run sets fail_o and latches fail_addr_o, fail_elem_o (1, 2 or 3) and fail_data_o. Later mismatches leave the record unchanged. fail_o stays high until the next start.
- R10: With stop_on_fail_i high at start, the first mismatch ends the run. That pass reports elem_fail_o = 1, no later pass runs, and done_o follows in the next cycle.
- R11: done_o is a one-cycle pulse. busy_o is high from the cycle after start until done_o, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| stop_on_fail_i | input | 1 | Abort on first mismatch when high |
| base_i | input | AW | First cell of the window |
| len_i | input | AW | Offset of the last cell (cell count minus one) |
| ram_rdata_i | input | DW | RAM read data, one cycle after the read |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| elem_done_o | output | 1 | One-cycle end-of-pass pulse |
| elem_id_o | output | 2 | Pass number for elem_done_o |
| elem_fail_o | output | 1 | Pass saw a mismatch |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | AW | Address of first mismatch |
| fail_elem_o | output | 2 | Pass of first mismatch |
| fail_data_o | output | DW | Word read at first mismatch |

## Verification
The bench builds the block with AW = 6 and DW = 8, a 64-cell RAM with 8-bit words. At that size every address, including wrap-around from cell 63 to cell 0, can be exercised, and per-bit stuck-at faults can be planted with single-bit data values that are easy to predict. Pairs of faulty cells expose the visiting order of the rising and falling passes. The small depth also keeps exact busy-cycle counts and full memory sweeps cheap.

// File: rtl/march_pkg.sv
package march_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_FIN   = 3'd4
    } mstate_e;

    localparam logic [1:0] LAST_ELEM = 2'd3;
endpackage

// File: rtl/march_addr_map.sv
module march_addr_map #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] last_i,
    input  logic [AW-1:0] off_i,
    input  logic          down_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] up_addr;
    logic [AW-1:0] dn_addr;

    always_comb begin
        up_addr = base_i + off_i;
        dn_addr = base_i + (last_i - off_i);
        addr_o  = down_i ? dn_addr : up_addr;
    end
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          chk_i,
    input  logic          exp_ones_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    elem_i,
    output logic          mism_o,
    output logic          fail_o,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    elem_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          hit;
        logic [AW-1:0] addr;
        logic [1:0]    elem;
        logic [DW-1:0] data;
    } rec_t;

    rec_t rec_d, rec_q;
    logic [DW-1:0] expect_w;

    always_comb begin
        expect_w = exp_ones_i ? {DW{1'b1}} : {DW{1'b0}};
        mism_o   = chk_i && (rdata_i != expect_w);
        rec_d    = rec_q;
        if (clr_i) begin
            rec_d = '0;
        end else if (mism_o && !rec_q.hit) begin
            rec_d.hit  = 1'b1;
            rec_d.addr = addr_i;
            rec_d.elem = elem_i;
            rec_d.data = rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign fail_o = rec_q.hit;
    assign addr_o = rec_q.addr;
    assign elem_o = rec_q.elem;
    assign data_o = rec_q.data;

    // R9
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clr_i) |=> (fail_o && $stable(addr_o) && $stable(elem_o) && $stable(data_o)));

    // R9
    rec_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (elem_o != 2'd0));
endmodule

// File: rtl/march_tester.sv
module march_tester
    import march_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_on_fail_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    input  logic [DW-1:0] ram_rdata_i,
    output logic          ram_en_o,
    output logic          ram_we_o,
    output logic [AW-1:0] ram_addr_o,
    output logic [DW-1:0] ram_wdata_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          elem_done_o,
    output logic [1:0]    elem_id_o,
    output logic          elem_fail_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o,
    output logic [1:0]    fail_elem_o,
    output logic [DW-1:0] fail_data_o
);
    localparam logic [AW-1:0] OFF_STEP = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        mstate_e       st;
        logic [1:0]    elem;
        logic [AW-1:0] off;
        logic [AW-1:0] base;
        logic [AW-1:0] last;
        logic          stop;
        logic          bad;
        logic          edone;
        logic [1:0]    eid;
        logic          efail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          go_down;
    logic          wr_ones;
    logic          exp_ones;
    logic          last_cell;
    logic          chk_en;
    logic          rec_clr;
    logic          mism;
    logic [AW-1:0] cell_addr;

    always_comb begin
        go_down   = ctl_q.elem[1];
        wr_ones   = ctl_q.elem[0];
        exp_ones  = (ctl_q.elem == 2'd2);
        last_cell = (ctl_q.off == ctl_q.last);
        chk_en    = (ctl_q.st == ST_WRITE);
        rec_clr   = (ctl_q.st == ST_IDLE) && start_i;
    end

    march_addr_map #(.AW(AW)) u_map (
        .base_i (ctl_q.base),
        .last_i (ctl_q.last),
        .off_i  (ctl_q.off),
        .down_i (go_down),
        .addr_o (cell_addr)
    );

    march_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (rec_clr),
        .chk_i      (chk_en),
        .exp_ones_i (exp_ones),
        .rdata_i    (ram_rdata_i),
        .addr_i     (cell_addr),
        .elem_i     (ctl_q.elem),
        .mism_o     (mism),
        .fail_o     (fail_o),
        .addr_o     (fail_addr_o),
        .elem_o     (fail_elem_o),
        .data_o     (fail_data_o)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.edone = 1'b0;
        ctl_d.efail = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_FILL;
                    ctl_d.elem = 2'd0;
                    ctl_d.off  = '0;
                    ctl_d.base = base_i;
                    ctl_d.last = len_i;
                    ctl_d.stop = stop_on_fail_i;
                    ctl_d.bad  = 1'b0;
                end
            end
            ST_FILL: begin
                if (last_cell) begin
                    ctl_d.edone = 1'b1;
                    ctl_d.eid   = 2'd0;
                    ctl_d.elem  = 2'd1;
                    ctl_d.off   = '0;
                    ctl_d.st    = ST_READ;
                end else begin
                    ctl_d.off = ctl_q.off + OFF_STEP;
                end
            end
            ST_READ: begin
                ctl_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (mism && ctl_q.stop) begin
                    ctl_d.edone = 1'b1;
                    ctl_d.eid   = ctl_q.elem;
                    ctl_d.efail = 1'b1;
                    ctl_d.st    = ST_FIN;
                end else if (last_cell) begin
                    ctl_d.edone = 1'b1;
                    ctl_d.eid   = ctl_q.elem;
                    ctl_d.efail = ctl_q.bad || mism;
                    ctl_d.bad   = 1'b0;
                    if (ctl_q.elem == LAST_ELEM) begin
                        ctl_d.st = ST_FIN;
                    end else begin
                        ctl_d.elem = ctl_q.elem + 2'd1;
                        ctl_d.off  = '0;
                        ctl_d.st   = ST_READ;
                    end
                end else begin
                    ctl_d.bad = ctl_q.bad || mism;
                    ctl_d.off = ctl_q.off + OFF_STEP;
                    ctl_d.st  = ST_READ;
                end
            end
            ST_FIN: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        busy_o      = (ctl_q.st == ST_FILL) || (ctl_q.st == ST_READ) || (ctl_q.st == ST_WRITE);
        done_o      = (ctl_q.st == ST_FIN);
        ram_en_o    = busy_o;
        ram_we_o    = (ctl_q.st == ST_FILL) || (ctl_q.st == ST_WRITE);
        ram_addr_o  = cell_addr;
        ram_wdata_o = ((ctl_q.st == ST_WRITE) && wr_ones) ? {DW{1'b1}} : {DW{1'b0}};
        elem_done_o = ctl_q.edone;
        elem_id_o   = ctl_q.eid;
        elem_fail_o = ctl_q.efail;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8
    elem0_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done_o && elem_id_o == 2'd0) |-> !elem_fail_o);

    // R2
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> ram_en_o);

    // R7
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en_o && !ram_we_o) |=> (ram_we_o && ram_addr_o == $past(ram_addr_o)));

    // R10
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.stop && $rose(fail_o)) |-> done_o);
endmodule

// File: tb/march_tester_bench.sv
module march_tester_bench;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_on_fail_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW-1:0] len_i = '0;
    logic [DW-1:0] ram_rdata_i;
    logic          ram_en_o, ram_we_o;
    logic [AW-1:0] ram_addr_o;
    logic [DW-1:0] ram_wdata_o;
    logic          busy_o, done_o, elem_done_o, elem_fail_o, fail_o;
    logic [1:0]    elem_id_o, fail_elem_o;
    logic [AW-1:0] fail_addr_o;
    logic [DW-1:0] fail_data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    march_tester #(.AW(AW), .DW(DW)) u_march_tester (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_on_fail_i(stop_on_fail_i),
        .base_i(base_i), .len_i(len_i), .ram_rdata_i(ram_rdata_i),
        .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
        .ram_wdata_o(ram_wdata_o), .busy_o(busy_o), .done_o(done_o),
        .elem_done_o(elem_done_o), .elem_id_o(elem_id_o), .elem_fail_o(elem_fail_o),
        .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_elem_o(fail_elem_o),
        .fail_data_o(fail_data_o)
    );

    // RAM model: single port, one-cycle read latency, stuck-at masks applied on read
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] sa1 [DEPTH];
    logic [DW-1:0] sa0 [DEPTH];
    int n_rd = 0;
    int n_wr = 0;
    int n_out = 0;
    int run_base = 0;
    int run_len = 0;

    always_ff @(posedge clk) begin
        if (ram_en_o) begin
            if (((int'(ram_addr_o) - run_base + DEPTH) % DEPTH) > run_len) n_out <= n_out + 1;
            if (ram_we_o) begin
                mem[ram_addr_o] <= ram_wdata_o;
                n_wr <= n_wr + 1;
            end else begin
                ram_rdata_i <= (mem[ram_addr_o] | sa1[ram_addr_o]) & ~sa0[ram_addr_o];
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard of expected per-pass reports
    typedef struct { int id; int fl; } ev_t;
    ev_t exp_q[$];

    task automatic push_ev(input int id, input int fl);
        ev_t e;
        e.id = id; e.fl = fl;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && elem_done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected pass report", int'(elem_id_o), -1);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                check(int'(elem_id_o) == e.id, "R8", "pass id", int'(elem_id_o), e.id);
                check(int'(elem_fail_o) == e.fl, "R8", "pass fail flag", int'(elem_fail_o), e.fl);
            end
        end
    end

    task automatic clear_faults();
        for (int i = 0; i < DEPTH; i++) begin
            sa1[i] = '0;
            sa0[i] = '0;
        end
    endtask

    task automatic run(input int b, input int l, input bit stop, input bit poke,
                       input int exp_busy, input bit exp_fail, input int exp_fa,
                       input int exp_fe, input int exp_fd, input bit full);
        int cyc;
        int rd0, wr0;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hA5;
        run_base = b; run_len = l;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        n_out = 0;
        base_i = AW'(b); len_i = AW'(l); stop_on_fail_i = stop; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        base_i = AW'(b + 20);
        check(busy_o == 1'b1, "R11", "busy after start", int'(busy_o), 1);
        cyc = 0;
        while (!done_o) begin
            if (busy_o) cyc++;
            if (poke && cyc == 5) start_i = 1'b1;
            if (poke && cyc == 6) start_i = 1'b0;
            @(negedge clk);
        end
        check(busy_o == 1'b0, "R11", "busy low at done", int'(busy_o), 0);
        check(cyc == exp_busy, "R7", "busy cycles", cyc, exp_busy);
        check(fail_o == exp_fail, "R9", "fail flag", int'(fail_o), int'(exp_fail));
        if (exp_fail) begin
            check(int'(fail_addr_o) == exp_fa, "R9", "fail address", int'(fail_addr_o), exp_fa);
            check(int'(fail_elem_o) == exp_fe, "R9", "fail pass", int'(fail_elem_o), exp_fe);
            check(int'(fail_data_o) == exp_fd, "R9", "fail data", int'(fail_data_o), exp_fd);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R11", "done one cycle", int'(done_o), 0);
        check(exp_q.size() == 0, "R8", "missing pass reports", exp_q.size(), 0);
        check(n_out == 0, "R6", "accesses outside window", n_out, 0);
        if (full) begin
            check(n_rd - rd0 == 3 * (l + 1), "R7", "read count", n_rd - rd0, 3 * (l + 1));
            check(n_wr - wr0 == 4 * (l + 1), "R2", "write count", n_wr - wr0, 4 * (l + 1));
        end
        for (int i = 0; i < DEPTH; i++) begin
            bit inr;
            inr = ((i - b + DEPTH) % DEPTH) <= l;
            if (!inr) check(mem[i] == 8'hA5, "R6", "cell outside window", int'(mem[i]), 'hA5);
            else if (full) check(mem[i] == 8'hFF, "R5", "final cell value", int'(mem[i]), 'hFF);
        end
    endtask

    initial begin
        clear_faults();
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hA5;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy_o == 0, "R1", "busy in reset", int'(busy_o), 0);
        check(done_o == 0, "R1", "done in reset", int'(done_o), 0);
        check(fail_o == 0, "R1", "fail in reset", int'(fail_o), 0);
        check(ram_en_o == 0, "R1", "ram enable in reset", int'(ram_en_o), 0);
        check(elem_done_o == 0, "R1", "pass report in reset", int'(elem_done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && ram_en_o == 0, "R1", "idle after reset", int'(busy_o), 0);

        // R2 R3 R4 R5 R7: clean 16-cell run
        push_ev(0, 0); push_ev(1, 0); push_ev(2, 0); push_ev(3, 0);
        run(0, 15, 1'b0, 1'b0, 112, 1'b0, 0, 0, 0, 1'b1);

        // R3 R9: stuck-at-1 on bit 2 at cells 42 and 45, rising pass finds 42 first
        sa1[42] = 8'h04; sa1[45] = 8'h04;
        push_ev(0, 0); push_ev(1, 1); push_ev(2, 0); push_ev(3, 1);
        run(40, 7, 1'b0, 1'b0, 56, 1'b1, 42, 1, 8'h04, 1'b1);

        // R4 R9: stuck-at-0 on bit 5 at cells 10 and 14, falling pass finds 14 first
        clear_faults();
        sa0[10] = 8'h20; sa0[14] = 8'h20;
        push_ev(0, 0); push_ev(1, 0); push_ev(2, 1); push_ev(3, 0);
        run(8, 9, 1'b0, 1'b0, 70, 1'b1, 14, 2, 8'hDF, 1'b1);

        // R10: abort at first mismatch (cell 42 is third of pass 1)
        clear_faults();
        sa1[42] = 8'h04; sa1[45] = 8'h04;
        push_ev(0, 0); push_ev(1, 1);
        run(40, 7, 1'b1, 1'b0, 14, 1'b1, 42, 1, 8'h04, 1'b0);
        check(fail_o == 1'b1, "R9", "fail sticky while idle", int'(fail_o), 1);

        // R6 R11: wrapping window, start pulse while busy ignored, fail cleared by start
        clear_faults();
        push_ev(0, 0); push_ev(1, 0); push_ev(2, 0); push_ev(3, 0);
        run(60, 7, 1'b0, 1'b1, 56, 1'b0, 0, 0, 0, 1'b1);

        // R7 single-cell window
        push_ev(0, 0); push_ev(1, 0); push_ev(2, 0); push_ev(3, 0);
        run(33, 0, 1'b0, 1'b0, 7, 1'b0, 0, 0, 0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule